// File: doc/BRIEF.md
# Chip-Select Output Unit

This block drives a small set of output pins, each of which can act as a chip select for an external serial device or as a plain general-purpose output. Software controls the pins through three word registers on a simple single-cycle bus. A configuration register picks, for every pin, whether it is flagged as a chip select and whether its electrical output is inverted. An action register changes stored levels without a read-modify-write: its upper byte raises individual levels and its lower byte lowers them. A status register returns the stored levels.

Chip selects are known to software by numbers starting at 1, so chip select c lives at pin index c − 1 in every field. After reset every stored level is high, so active-low selects start released. Asserting an active-low select means lowering its level and releasing it means raising it. The pin count is a parameter of up to eight; six is the default and three suits a smaller build. The chip-select flags go to a neighbouring shift engine, which is not part of this block.

A two-state access controller handles reads. ST_IDLE waits; a read request moves it to ST_RESP (transition READ_ACCEPT), capturing the addressed register. ST_RESP presents the data for one cycle with the valid flag high. It stays in ST_RESP on a further read (READ_CHAIN) or returns to ST_IDLE otherwise (RESP_DONE). Writes take effect at the clock edge in either state.

Top module: `cs_output_unit`

## Requirements
- R1: After reset every stored level is 1, the configuration is all zero, every pin_out bit is 1 and every pin_cs_mode bit is 0.
- R2: A write to the action register (address 1) with data bit 8+n set drives the stored level of pin n to 1 from the next cycle; chip select c uses n = c − 1.
- R3: A write to the action register with data bit n set (and bit 8+n clear) drives the stored level of pin n to 0 from the next cycle.
- R4: Zero bits in an action write leave the matching pins unchanged, and an all-zero action write changes no pin.
- R5: When one action write has both bit 8+n and bit n set, pin n's level becomes 1 (raising wins).
- R6: A write to the configuration register (address 0) sets pin_cs_mode[n] from data bit 8+n and the invert flag of pin n from data bit n; pin_out[n] is the stored level XOR the invert flag.
- R7: A read of the status register (address 2) returns the stored, uninverted levels in bits NUM_PINS-1..0 and zero above; read data appears with bus_rvalid high in the cycle after the request, and bus_rvalid is low in a cycle not preceded by a read request.
- R8: A read of address 0 returns the configuration with chip-select flags in bits 8+n and invert flags in bits n; a read of address 1 returns zero.
- R9: Action and configuration data bits for pin indices at or above NUM_PINS are ignored: they change no pin and read back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Register select: 0 configuration, 1 action, 2 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read response valid |
| pin_out | output | NUM_PINS | Pin drive, stored level XOR invert flag |
| pin_cs_mode | output | NUM_PINS | Per-pin chip-select flag |

## Verification
The function pair that can meet in one cycle is raising and lowering the same pin, because both halves of a single action word are decoded together. The bench provokes this with an action word that carries both bits for one pin alongside a plain lowering bit for others. It judges the result on pin_out in the next cycle and through a status read, both compared against a model in which raising wins. Back-to-back reads also put a new read capture in the same cycle as the previous response, and the scoreboard checks that each response matches its own request.

// File: rtl/csout_pkg.sv
package csout_pkg;
    localparam int unsigned HALF_W = 8;
    localparam int unsigned DATA_W = 2 * HALF_W;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CFG  = 2'd0,
        REG_ACT  = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } acc_state_e;
endpackage

// File: rtl/cs_bus_fsm.sv
module cs_bus_fsm
    import csout_pkg::*;
#(
    parameter int unsigned NUM_PINS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [NUM_PINS-1:0] cfg_cs,
    input  logic [NUM_PINS-1:0] cfg_inv,
    input  logic [NUM_PINS-1:0] level,
    output logic                cfg_wr,
    output logic                act_wr,
    output logic [NUM_PINS-1:0] hi_bits,
    output logic [NUM_PINS-1:0] lo_bits,
    output logic [DATA_W-1:0]   rdata,
    output logic                rvalid
);
    localparam int unsigned PAD = HALF_W - NUM_PINS;

    acc_state_e         state_q, state_d;
    logic [DATA_W-1:0]  rdata_q;
    logic [DATA_W-1:0]  rmux;
    logic               rd_req;
    reg_sel_e           sel;

    assign sel     = reg_sel_e'(addr);
    assign rd_req  = req && !we;
    assign cfg_wr  = req && we && (sel == REG_CFG);
    assign act_wr  = req && we && (sel == REG_ACT);
    assign hi_bits = wdata[HALF_W +: NUM_PINS];
    assign lo_bits = wdata[0 +: NUM_PINS];

    generate
        if (PAD > 0) begin : g_pad
            logic unused_wbits;
            assign unused_wbits = ^{wdata[DATA_W-1:HALF_W+NUM_PINS],
                                    wdata[HALF_W-1:NUM_PINS]};
        end
    endgenerate

    always_comb begin
        rmux = '0;
        unique case (sel)
            REG_CFG: begin
                rmux[HALF_W +: NUM_PINS] = cfg_cs;
                rmux[0 +: NUM_PINS]      = cfg_inv;
            end
            REG_STAT: rmux[0 +: NUM_PINS] = level;
            REG_ACT:  rmux = '0;
            REG_NONE: rmux = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_req) state_d = ST_RESP;   // READ_ACCEPT
            ST_RESP: if (!rd_req) state_d = ST_IDLE;  // RESP_DONE / READ_CHAIN
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_req) rdata_q <= rmux;
        else             rdata_q <= '0;
    end

    always_comb begin
        rvalid = 1'b0;
        rdata  = '0;
        unique case (state_q)
            ST_IDLE: rvalid = 1'b0;
            ST_RESP: begin
                rvalid = 1'b1;
                rdata  = rdata_q;
            end
        endcase
    end

    // R7: a read request is answered in the next cycle
    a_r7_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we) |=> rvalid);
    // R7: no response without a request
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && !we) |=> !rvalid);
endmodule

// File: rtl/cs_cfg_reg.sv
module cs_cfg_reg #(
    parameter int unsigned NUM_PINS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [NUM_PINS-1:0] cs_d,
    input  logic [NUM_PINS-1:0] inv_d,
    output logic [NUM_PINS-1:0] cs_q,
    output logic [NUM_PINS-1:0] inv_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= '0;
            inv_q <= '0;
        end else if (wr) begin
            cs_q  <= cs_d;
            inv_q <= inv_d;
        end
    end

    // R6: configuration written is what the next cycle shows
    a_r6_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (cs_q == $past(cs_d)) && (inv_q == $past(inv_d)));
    // R6: configuration holds without a write
    a_r6_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(cs_q) && $stable(inv_q));
endmodule

// File: rtl/cs_level_bank.sv
module cs_level_bank #(
    parameter int unsigned NUM_PINS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [NUM_PINS-1:0] raise,
    input  logic [NUM_PINS-1:0] lower,
    output logic [NUM_PINS-1:0] level
);
    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                level[i] <= 1'b1;
                else if (wr && raise[i])   level[i] <= 1'b1;
                else if (wr && lower[i])   level[i] <= 1'b0;
            end

            // R2 and R5: a raise bit always leaves the level high
            a_r5_raise_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (wr && raise[i]) |=> level[i]);
            // R3: a lone lower bit leaves the level low
            a_r3_lower: assert property (@(posedge clk) disable iff (!rst_n)
                (wr && lower[i] && !raise[i]) |=> !level[i]);
            // R4: no bit for this pin, no change
            a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr && (raise[i] || lower[i])) |=> $stable(level[i]));
        end
    endgenerate
endmodule

// File: rtl/cs_output_unit.sv
module cs_output_unit
    import csout_pkg::*;
#(
    parameter int unsigned NUM_PINS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_rvalid,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_cs_mode
);
    logic                cfg_wr, act_wr;
    logic [NUM_PINS-1:0] hi_bits, lo_bits;
    logic [NUM_PINS-1:0] cfg_inv, level;

    cs_bus_fsm #(.NUM_PINS(NUM_PINS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (bus_req),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .cfg_cs  (pin_cs_mode),
        .cfg_inv (cfg_inv),
        .level   (level),
        .cfg_wr  (cfg_wr),
        .act_wr  (act_wr),
        .hi_bits (hi_bits),
        .lo_bits (lo_bits),
        .rdata   (bus_rdata),
        .rvalid  (bus_rvalid)
    );

    cs_cfg_reg #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .cs_d  (hi_bits),
        .inv_d (lo_bits),
        .cs_q  (pin_cs_mode),
        .inv_q (cfg_inv)
    );

    cs_level_bank #(.NUM_PINS(NUM_PINS)) u_lvl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (act_wr),
        .raise (hi_bits),
        .lower (lo_bits),
        .level (level)
    );

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_drv
            assign pin_out[i] = level[i] ^ cfg_inv[i];
        end
    endgenerate

    initial begin
        a_r9_pin_count: assert (NUM_PINS >= 1 && NUM_PINS <= HALF_W);
    end
endmodule

// File: tb/cs_output_unit_test.sv
module cs_output_unit_test;
    localparam int N = 6;
    localparam logic [N-1:0] ALL = {N{1'b1}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_rvalid;
    logic [N-1:0] pin_out, pin_cs_mode;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [N-1:0] m_lvl = ALL;
    logic [N-1:0] m_cs = '0;
    logic [N-1:0] m_inv = '0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    cs_output_unit #(.NUM_PINS(N)) uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pin_out(pin_out), .pin_cs_mode(pin_cs_mode)
    );

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    function automatic logic [15:0] model_read(logic [1:0] a);
        logic [15:0] v = '0;
        if (a == 2'd0) begin
            v[8 +: N] = m_cs;
            v[0 +: N] = m_inv;
        end else if (a == 2'd2) begin
            v[0 +: N] = m_lvl;
        end
        return v;
    endfunction

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        if (a == 2'd1) m_lvl = (m_lvl & ~d[0 +: N]) | d[8 +: N];
        if (a == 2'd0) begin
            m_cs = d[8 +: N];
            m_inv = d[0 +: N];
        end
    endtask

    task automatic rd(logic [1:0] a, string tag);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic pins(string tag);
        check({tag, " pin_out"}, 16'(pin_out), 16'(m_lvl ^ m_inv));
        check({tag, " pin_cs_mode"}, 16'(pin_cs_mode), 16'(m_cs));
    endtask

    // monitor: pops the scoreboard on each response
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R7 spurious response: got %h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        pins("R1 reset");
        check("R7 rvalid idle", 16'(bus_rvalid), 16'h0);
        rd(2'd2, "R1 R7 status after reset");
        rd(2'd0, "R1 R8 cfg after reset");

        wr(2'd1, 16'h0001);                 // assert CS1 = pin 0
        pins("R3 lower pin0");
        wr(2'd1, 16'h0000);
        pins("R4 zero write");
        rd(2'd2, "R4 status after zero write");
        wr(2'd1, 16'h0100);
        pins("R2 raise pin0");
        wr(2'd1, 16'h002A);
        pins("R3 lower pins 1 3 5");
        check("R3 literal", 16'(pin_out), 16'h0015);
        wr(2'd1, 16'h0203);                 // pin1 both, pin0 lower
        pins("R5 raise wins");
        check("R5 literal", 16'(pin_out), 16'h0016);
        rd(2'd2, "R5 status");
        wr(2'd1, 16'hC0C0);
        pins("R9 high action bits");
        rd(2'd2, "R9 status after high bits");

        wr(2'd0, 16'h0703);
        pins("R6 cfg cs+invert");
        check("R6 literal", 16'(pin_out), 16'h0015);
        rd(2'd2, "R7 status uninverted");
        rd(2'd0, "R8 cfg readback");
        rd(2'd1, "R8 action reads zero");
        wr(2'd0, 16'hFFFF);
        pins("R9 cfg wide write");
        rd(2'd0, "R9 cfg readback masked");

        // back-to-back reads
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 2'd2;
        exp_q.push_back(model_read(2'd2)); tag_q.push_back("R7 chained read 1");
        @(negedge clk);
        bus_addr = 2'd0;
        exp_q.push_back(model_read(2'd0)); tag_q.push_back("R7 chained read 2");
        @(negedge clk);
        bus_req = 1'b0;
        @(negedge clk);
        check("R7 rvalid drops", 16'(bus_rvalid), 16'h0);

        // walk each chip select number c on pin c-1
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h3F00);
        for (int c = 1; c <= N; c++) begin
            wr(2'd1, 16'(1) << (c - 1));
            pins($sformatf("R3 assert CS%0d", c));
            wr(2'd1, 16'(1) << (c - 1 + 8));
            pins($sformatf("R2 release CS%0d", c));
        end

        repeat (3) @(negedge clk);
        check("R7 scoreboard drained", 16'(exp_q.size()), 16'h0);
        summary();
    end
endmodule